// File: doc/BRIEF.md
# Cascadable Parallel-Load Shift Register with Tristate Outputs

This block is a shift register built from 4-bit slices that update on the falling clock edge. A mode input chooses between two operations. When the mode is high, the slice captures its four parallel data bits. When the mode is low, the register shifts one position toward the higher stages and the serial input enters stage 0.

An active-low clear acts asynchronously and empties the whole register. An active-low output enable controls the parallel outputs. When it is low they drive the register contents. When it is high they float, so several blocks can share one bus. The output enable has no effect on the stored data.

The top level chains `SLICES` slices. Each slice's last-stage output feeds the next slice's serial input, so together they form one `4*SLICES`-bit register. The final stage appears on an always-driven serial output, which can extend the chain further.

Top module: `shreg_chain`

## Requirements
- R1: All register updates happen on the falling edge of `clk`. A rising edge changes nothing.
- R2: If `load` is 1 at a falling edge, the register takes `par_in`. Bit 4k+j of `par_in` goes to stage j of slice k.
- R3: If `load` is 0 at a falling edge, `ser_in` enters register bit 0 and every bit i moves to bit i+1.
- R4: While `clr_n` is 0, every stage reads 0 at once, without waiting for a clock edge. Clock edges, `load` and data have no effect during this time.
- R5: When `oe_n` is 0, `par_out` drives the register contents. When `oe_n` is 1, all `par_out` bits are high impedance, so another driver on the bus wins.
- R6: `oe_n` never changes the stored data or the load and shift operations.
- R7: `ser_out` always equals the highest register bit, whatever the value of `oe_n`.
- R8: Slice k stage 0 takes slice k-1 stage 3 on a shift. The chain therefore behaves as one `4*SLICES`-bit register.
- R9: Changes of `load`, `ser_in` and `par_in` between falling edges have no effect on the result.
- R10: The first falling edge after `clr_n` returns to 1 performs a normal load or shift, starting from the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, active on the falling edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| load | input | 1 | Mode: 1 = parallel load, 0 = shift |
| ser_in | input | 1 | Serial data into stage 0 of slice 0 |
| par_in | input | 4*SLICES | Parallel data, bit 4k+j for slice k stage j |
| oe_n | input | 1 | Output enable for `par_out`, active low |
| par_out | output | 4*SLICES | Tristate parallel outputs |
| ser_out | output | 1 | Last stage of the last slice, always driven |

## Verification
Loads use all-ones, alternating and mixed words. These separate a correct capture from bit reversal, and from slices that are swapped or tied together. Serial streams are long enough to cross every slice boundary and reach `ser_out`, which exposes a broken link between slices or a wrong shift direction. Shifts run with the outputs disabled while the bench drives the complement of the expected data onto the bus, which detects any leakage through the drivers. Glitches on the inputs between edges, and a clear asserted in the middle of a cycle with a load held during it, check edge sampling and that the clear takes priority.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  localparam int SLICE_W = 4;

  typedef enum logic {
    MODE_SHIFT = 1'b0,
    MODE_LOAD  = 1'b1
  } mode_e;
endpackage

// File: rtl/shreg_slice.sv
module shreg_slice
  import shreg_pkg::*;
#(
  parameter int SW = SLICE_W
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          load,
  input  logic          ser_in,
  input  logic [SW-1:0] par_in,
  output logic [SW-1:0] q,
  output logic          ser_out
);
  mode_e mode;
  assign mode = mode_e'(load);

  // falling-edge register, asynchronous active-low clear
  always_ff @(negedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= '0;
    end else if (mode == MODE_LOAD) begin
      q <= par_in;
    end else begin
      q <= {q[SW-2:0], ser_in};
    end
  end

  assign ser_out = q[SW-1];
endmodule

// File: rtl/shreg_tri_drv.sv
module shreg_tri_drv #(
  parameter int W = 4
) (
  input  logic         oe_n,
  input  logic [W-1:0] d,
  output wire  [W-1:0] y
);
  assign y = oe_n ? {W{1'bz}} : d;
endmodule

// File: rtl/shreg_chain.sv
module shreg_chain
  import shreg_pkg::*;
#(
  parameter int SLICES = 3
) (
  input  logic                    clk,
  input  logic                    clr_n,
  input  logic                    load,
  input  logic                    ser_in,
  input  logic [SLICES*SLICE_W-1:0] par_in,
  input  logic                    oe_n,
  output wire  [SLICES*SLICE_W-1:0] par_out,
  output logic                    ser_out
);
  localparam int W = SLICES * SLICE_W;

  logic [SLICES:0] link;
  logic [W-1:0]    q_all;

  assign link[0] = ser_in;

  generate
    for (genvar k = 0; k < SLICES; k++) begin : g_slice
      shreg_slice #(.SW(SLICE_W)) u_slice (
        .clk     (clk),
        .clr_n   (clr_n),
        .load    (load),
        .ser_in  (link[k]),
        .par_in  (par_in[k*SLICE_W +: SLICE_W]),
        .q       (q_all[k*SLICE_W +: SLICE_W]),
        .ser_out (link[k+1])
      );
    end
  endgenerate

  shreg_tri_drv #(.W(W)) u_drv (
    .oe_n (oe_n),
    .d    (q_all),
    .y    (par_out)
  );

  assign ser_out = link[SLICES];
endmodule

// File: rtl/shreg_chain_chk.sv
module shreg_chain_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         clr_n,
  input logic         load,
  input logic         ser_in,
  input logic [W-1:0] par_in,
  input logic         oe_n,
  input logic [W-1:0] q,
  input logic [W-1:0] par_out,
  input logic         ser_out
);
  AST_LOAD_CAPTURE: assert property (@(negedge clk) disable iff (!clr_n)
    load |=> (q == $past(par_in)));  // R2

  AST_SHIFT_STEP: assert property (@(negedge clk) disable iff (!clr_n)
    !load |=> (q == {$past(q[W-2:0]), $past(ser_in)}));  // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk)
    !clr_n |-> (q == '0));  // R4

  AST_BUS_DRIVEN: assert property (@(posedge clk) disable iff (!clr_n)
    !oe_n |-> (par_out == q));  // R5

  AST_SER_TAP: assert property (@(posedge clk) disable iff (!clr_n)
    ser_out == q[W-1]);  // R7
endmodule

bind shreg_chain shreg_chain_chk #(.W(SLICES*shreg_pkg::SLICE_W)) u_chk (
  .clk     (clk),
  .clr_n   (clr_n),
  .load    (load),
  .ser_in  (ser_in),
  .par_in  (par_in),
  .oe_n    (oe_n),
  .q       (q_all),
  .par_out (par_out),
  .ser_out (ser_out)
);

// File: tb/sim_shreg_chain.sv
`timescale 1ns/1ps
module sim_shreg_chain;
  localparam int SLICES = 3;
  localparam int W = SLICES * 4;
  localparam int WD_CYCLES = 20000;

  logic         clk = 1'b1;
  logic         clr_n = 1'b0;
  logic         load = 1'b0;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         oe_n = 1'b0;
  wire  [W-1:0] bus;
  logic         ser_out;

  logic [W-1:0] mdl;
  logic         chk_en = 1'b0;
  logic         done = 1'b0;
  string        cur_req = "R10";
  int           n_run = 0;
  int           n_fail = 0;

  always #2.5 clk = ~clk;

  // another bus driver: drives the complement of the model while the block is off
  assign bus = oe_n ? ~mdl : {W{1'bz}};

  shreg_chain #(.SLICES(SLICES)) u0 (
    .clk(clk), .clr_n(clr_n), .load(load), .ser_in(ser_in),
    .par_in(par_in), .oe_n(oe_n), .par_out(bus), .ser_out(ser_out)
  );

  // behavioural reference: a plain bit vector
  always @(negedge clk or negedge clr_n) begin
    if (!clr_n) mdl <= '0;
    else if (load) mdl <= par_in;
    else mdl <= {mdl[W-2:0], ser_in};
  end

  task automatic check(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (chk_en) begin
      logic [W-1:0] exp_bus;
      exp_bus = oe_n ? ~mdl : mdl;
      check(bus === exp_bus, cur_req, bus, exp_bus);
      check(ser_out === mdl[W-1], "R7", {{(W-1){1'b0}}, ser_out},
            {{(W-1){1'b0}}, mdl[W-1]});
    end
  end

  task automatic drive(input logic ld, input logic si, input logic [W-1:0] pd,
                       input logic oe, input string tag);
    @(posedge clk);
    #0.5;
    load = ld; ser_in = si; par_in = pd; oe_n = oe; cur_req = tag;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(WD_CYCLES * 5.0);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    logic [W-1:0] a;
    logic [W-1:0] b;
    // reset state (R4)
    repeat (2) @(posedge clk);
    #1;
    check(bus === '0, "R4", bus, '0);
    check(ser_out === 1'b0, "R4", {{(W-1){1'b0}}, ser_out}, '0);

    // release, first edge shifts a 1 into all-zero state (R10)
    @(posedge clk); #0.5;
    clr_n = 1'b1; load = 1'b0; ser_in = 1'b1; cur_req = "R10";
    chk_en = 1'b1;

    // parallel loads (R2)
    drive(1'b1, 1'b0, '1, 1'b0, "R2");
    drive(1'b1, 1'b0, 12'hA5C, 1'b0, "R2");
    drive(1'b1, 1'b1, 12'h3C6, 1'b0, "R2");
    drive(1'b1, 1'b0, 12'h555, 1'b0, "R2");

    // shifts across slice boundaries (R3, R8)
    for (int i = 0; i < 2*W; i++)
      drive(1'b0, (i % 3) == 0, 12'hFFF, 1'b0, (i < 4) ? "R3" : "R8");

    // outputs off while shifting, bus must follow other driver (R5, R6)
    for (int i = 0; i < W; i++)
      drive(1'b0, i[0], '0, 1'b1, "R5");
    drive(1'b1, 1'b0, 12'h9E1, 1'b1, "R6");
    drive(1'b0, 1'b1, '0, 1'b0, "R6");
    drive(1'b0, 1'b0, '0, 1'b0, "R6");

    // glitches between edges, rising edge changes nothing (R1, R9)
    for (int g = 0; g < 4; g++) begin
      logic sl; logic ss; logic [W-1:0] sp;
      drive(g[0], ~g[1], 12'h6B2 ^ {W{g[0]}}, 1'b0, "R9");
      @(negedge clk); #0.5;
      sl = load; ss = ser_in; sp = par_in;
      load = ~sl; ser_in = ~ss; par_in = ~sp;
      #1.5; a = bus;
      @(posedge clk); #0.5; b = bus;
      check(a === b, "R1", b, a);
      load = sl; ser_in = ss; par_in = sp;
    end

    // asynchronous clear mid-cycle with a load held (R4), then release (R10)
    drive(1'b1, 1'b0, 12'hF0F, 1'b0, "R2");
    @(posedge clk); #1;
    clr_n = 1'b0; load = 1'b1; par_in = '1; cur_req = "R4";
    #0.5;
    check(bus === '0, "R4", bus, '0);
    @(posedge clk); #0.5;
    clr_n = 1'b1; load = 1'b0; ser_in = 1'b1; cur_req = "R10";
    drive(1'b0, 1'b0, '0, 1'b0, "R3");

    // mixed traffic (R8)
    for (int i = 0; i < 200; i++)
      drive(($urandom % 4) == 0, $urandom % 2, W'($urandom),
            ($urandom % 5) == 0, "R8");

    @(posedge clk); #1;
    chk_en = 1'b0;
    done = 1'b1;
    summary();
  end
endmodule